// File: doc/BRIEF.md
# Bidirectional Column Data Loader

This block fills one display line of 6-bit pixel codes into a column register that a later line latch picks up. Every clock period brings three neighbouring channel codes over nine data lanes. Each lane is sampled on both clock edges, so one lane carries two bits of one code. A one-hot token walks across the line's triple-channel positions and marks where each incoming triple is stored. The token can walk upward from channel 1 or downward from the top channel.

A start pulse arms the token. When the last triple arrives, a carry pulse is raised so that the next loader in a chain can take over on the following period. The start and carry functions share two side ports whose roles swap with the fill direction. A 2-bit span select removes a block of central channels from the walk, which gives narrower builds. The token jumps over the removed block, and those cycles are not spent.

Top module: `col_loader`

## Requirements
- R1: While reset is asserted and after its release, all register slots read zero, both carry outputs are low, and no stored value changes until a start pulse is seen.
- R2: Channel 3p+g (0-based) at token position p takes its code from group g. Group g lane l is at lane-bus bit g*3+l. That lane carries code bit 2l during the high half of the clock, sampled at the falling edge, and code bit 2l+1 during the low half, sampled at the next rising edge. The code for channel c appears at `cols_o[6c+5:6c]`.
- R3: With `dir_i`=1, the start pulse is taken from `rport_in`. The first period after the edge that samples it fills channels 0..2, and each later period fills the next higher triple.
- R4: With `dir_i`=0, the start pulse is taken from `lport_in`. The first period fills channels 639..641, and each later period fills the next lower triple.
- R5: With `dir_i`=1, `lport_oe`=1, `rport_oe`=0 and `lport_out` carries the carry. With `dir_i`=0 the roles are swapped. The port that is not driving outputs 0.
- R6: The carry is high for exactly one clock period, and that period is the one that brings the line's final triple.
- R7: `span_i`=00 uses all 214 positions, 01 uses 210, 10 uses 206 and 11 uses 200. The carry appears in the period of the last used position.
- R8: The removed channels are never written. They are 0-based 315..326 for 01, 309..332 for 10 and 300..341 for 11, and they keep their earlier contents.
- R9: A start pulse may be one or two periods wide. A start seen while a line is being filled restarts it from the first position. The data in the period of a sampled start is not stored.
- R10: Once the final triple has been stored, further clocks with lane activity leave the register unchanged and the carry low until a new start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; lanes sampled on both edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | 1: fill upward from channel 0; 0: fill downward from the top |
| span_i | input | 2 | Central-channel removal select |
| lanes_i | input | 9 | Double-rate data lanes, group g lane l at bit g*3+l |
| rport_in | input | 1 | Right side port: start input when dir_i=1 |
| rport_out | output | 1 | Right side port: carry output when dir_i=0 |
| rport_oe | output | 1 | Right side port drive enable |
| lport_in | input | 1 | Left side port: start input when dir_i=0 |
| lport_out | output | 1 | Left side port: carry output when dir_i=1 |
| lport_oe | output | 1 | Left side port drive enable |
| cols_o | output | 3852 | Register contents, 642 codes of 6 bits |

## Verification
The bench builds the block with its default values: 214 positions, three groups of three lanes, and removal widths of 4, 8 and 14 positions. These are the values at which the removed blocks fall exactly on channel ranges 315..326, 309..332 and 300..341. With these values, all four line lengths can be reached in both fill directions. The position just before and just after each removed block can be exercised, which is where the token's jump logic matters. Each pass has different codes from the previous one, so a stray write into a removed block, or a write to a wrong slot, shows up as a changed value.

// File: rtl/col_loader_pkg.sv
`timescale 1ns/1ps
package col_loader_pkg;

   // Central-channel removal select; the encoding is visible at the top port.
   typedef enum logic [1:0] {
      SPAN_FULL   = 2'b00,
      SPAN_NARROW = 2'b01,
      SPAN_MID    = 2'b10,
      SPAN_WIDE   = 2'b11
   } span_e;

endpackage

// File: rtl/col_ddr_rx.sv
`timescale 1ns/1ps
module col_ddr_rx #(
   parameter int GROUPS = 3,
   parameter int LANES  = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [GROUPS*LANES-1:0]      lanes_i,
   output logic [GROUPS*2*LANES-1:0]    codes_o
);
   localparam int LANE_BITS = GROUPS * LANES;
   localparam int CODE_W    = 2 * LANES;

   // First-half bits, taken at the falling edge.
   logic [LANE_BITS-1:0] half_q;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) half_q <= '0;
      else        half_q <= lanes_i;
   end

   // Even code bits come from the stored half, odd bits from the live lanes
   // at the rising edge that stores the triple.
   genvar g, l;
   generate
      for (g = 0; g < GROUPS; g++) begin : g_grp
         for (l = 0; l < LANES; l++) begin : g_lane
            assign codes_o[g*CODE_W + 2*l]     = half_q[g*LANES + l];
            assign codes_o[g*CODE_W + 2*l + 1] = lanes_i[g*LANES + l];
         end
      end
   endgenerate

endmodule

// File: rtl/col_token.sv
`timescale 1ns/1ps
module col_token
   import col_loader_pkg::*;
#(
   parameter int POSITIONS   = 214,
   parameter int SKIP_NARROW = 4,
   parameter int SKIP_MID    = 8,
   parameter int SKIP_WIDE   = 14
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic                 dir_i,
   input  span_e                span_i,
   output logic [POSITIONS-1:0] tok_o,
   output logic                 carry_o
);
   localparam int SKIPS [3] = '{SKIP_NARROW, SKIP_MID, SKIP_WIDE};

   generate
      if (SKIP_NARROW < 1 || SKIP_NARROW >= SKIP_MID || SKIP_MID >= SKIP_WIDE ||
          SKIP_WIDE > POSITIONS - 2) begin : g_bad_skip
         $error("col_token: removal widths must grow and leave a position on each side");
      end
   endgenerate

   logic [POSITIONS-1:0] tok_q;
   logic [POSITIONS-1:0] nxt;
   logic [POSITIONS-1:0] keep;
   logic [POSITIONS-1:0] first;

   genvar p, k;
   generate
      for (p = 0; p < POSITIONS; p++) begin : g_pos
         logic [2:0] drop;
         logic [2:0] jup;
         logic [2:0] jdn;
         logic       from_lo;
         logic       from_hi;

         for (k = 0; k < 3; k++) begin : g_mode
            localparam int LO = (POSITIONS - SKIPS[k]) / 2;
            localparam int HI = LO + SKIPS[k] - 1;
            assign drop[k] = (span_i == span_e'(2'(k + 1))) && (p >= LO) && (p <= HI);
            if (p == HI + 1) begin : g_jup
               assign jup[k] = (span_i == span_e'(2'(k + 1))) & tok_q[LO-1];
            end else begin : g_nojup
               assign jup[k] = 1'b0;
            end
            if (p == LO - 1) begin : g_jdn
               assign jdn[k] = (span_i == span_e'(2'(k + 1))) & tok_q[HI+1];
            end else begin : g_nojdn
               assign jdn[k] = 1'b0;
            end
         end

         assign keep[p] = ~|drop;

         if (p == 0) begin : g_lo_edge
            assign from_lo = 1'b0;
         end else begin : g_lo_step
            assign from_lo = tok_q[p-1] & keep[p];
         end
         if (p == POSITIONS - 1) begin : g_hi_edge
            assign from_hi = 1'b0;
         end else begin : g_hi_step
            assign from_hi = tok_q[p+1] & keep[p];
         end

         assign nxt[p] = dir_i ? (from_lo | (|jup)) : (from_hi | (|jdn));
      end
   endgenerate

   assign first = dir_i ? POSITIONS'(1) : {1'b1, {(POSITIONS-1){1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tok_q <= '0;
      else if (start_i) tok_q <= first;
      else              tok_q <= nxt;
   end

   assign tok_o   = tok_q;
   assign carry_o = dir_i ? tok_q[POSITIONS-1] : tok_q[0];

   // R3
   token_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tok_q));
   // R8
   skip_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_q & ~keep) == '0);
   // R6
   carry_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      carry_o |=> !carry_o);
   // R9
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> $onehot(tok_q));

endmodule

// File: rtl/col_port_mux.sv
`timescale 1ns/1ps
module col_port_mux (
   input  logic dir_i,
   input  logic carry_i,
   input  logic rport_in,
   input  logic lport_in,
   output logic start_o,
   output logic rport_out,
   output logic rport_oe,
   output logic lport_out,
   output logic lport_oe
);
   // Upward fill: start enters on the right, carry leaves on the left.
   assign start_o   = dir_i ? rport_in : lport_in;
   assign lport_oe  = dir_i;
   assign rport_oe  = ~dir_i;
   assign lport_out = dir_i & carry_i;
   assign rport_out = ~dir_i & carry_i;

endmodule

// File: rtl/col_loader.sv
`timescale 1ns/1ps
module col_loader
   import col_loader_pkg::*;
#(
   parameter int POSITIONS   = 214,
   parameter int GROUPS      = 3,
   parameter int LANES       = 3,
   parameter int SKIP_NARROW = 4,
   parameter int SKIP_MID    = 8,
   parameter int SKIP_WIDE   = 14
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   dir_i,
   input  logic [1:0]                             span_i,
   input  logic [GROUPS*LANES-1:0]                lanes_i,
   input  logic                                   rport_in,
   output logic                                   rport_out,
   output logic                                   rport_oe,
   input  logic                                   lport_in,
   output logic                                   lport_out,
   output logic                                   lport_oe,
   output logic [POSITIONS*GROUPS*2*LANES-1:0]    cols_o
);
   localparam int CODE_W = 2 * LANES;
   localparam int SLOT_W = GROUPS * CODE_W;

   generate
      if (GROUPS < 1 || LANES < 1 || POSITIONS < 4) begin : g_bad_shape
         $error("col_loader: groups, lanes and positions out of range");
      end
   endgenerate

   logic                 start;
   logic                 carry;
   logic [POSITIONS-1:0] tok;
   logic [SLOT_W-1:0]    codes;

   col_port_mux u_ports (
      .dir_i    (dir_i),
      .carry_i  (carry),
      .rport_in (rport_in),
      .lport_in (lport_in),
      .start_o  (start),
      .rport_out(rport_out),
      .rport_oe (rport_oe),
      .lport_out(lport_out),
      .lport_oe (lport_oe)
   );

   col_ddr_rx #(
      .GROUPS(GROUPS),
      .LANES (LANES)
   ) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .lanes_i(lanes_i),
      .codes_o(codes)
   );

   col_token #(
      .POSITIONS  (POSITIONS),
      .SKIP_NARROW(SKIP_NARROW),
      .SKIP_MID   (SKIP_MID),
      .SKIP_WIDE  (SKIP_WIDE)
   ) u_tok (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start),
      .dir_i  (dir_i),
      .span_i (span_e'(span_i)),
      .tok_o  (tok),
      .carry_o(carry)
   );

   genvar p;
   generate
      for (p = 0; p < POSITIONS; p++) begin : g_slot
         logic [SLOT_W-1:0] slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  slot_q <= '0;
            else if (tok[p] && !start)   slot_q <= codes;
         end
         assign cols_o[p*SLOT_W +: SLOT_W] = slot_q;
      end
   endgenerate

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tok == '0 && !start) |=> $stable(cols_o));

endmodule

// File: tb/col_loader_bench.sv
`timescale 1ns/1ps
module col_loader_bench;
   localparam int POS = 214;
   localparam int GR  = 3;
   localparam int LN  = 3;
   localparam int CH  = POS * GR;

   typedef struct packed {
      logic       dir;
      logic [1:0] span;
      logic [7:0] seed;
   } scen_t;

   // Both directions, every span; a full line precedes each run of narrowed lines.
   localparam scen_t SCEN [8] = '{
      '{1'b1, 2'b00, 8'd3},  '{1'b1, 2'b11, 8'd17}, '{1'b1, 2'b10, 8'd29},
      '{1'b1, 2'b01, 8'd41}, '{1'b0, 2'b00, 8'd55}, '{1'b0, 2'b01, 8'd66},
      '{1'b0, 2'b10, 8'd78}, '{1'b0, 2'b11, 8'd90}
   };

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 dir_i = 1'b1;
   logic [1:0]           span_i = 2'b00;
   logic [GR*LN-1:0]     lanes_i = '0;
   logic                 rport_in = 1'b0;
   logic                 lport_in = 1'b0;
   logic                 rport_out, rport_oe, lport_out, lport_oe;
   logic [CH*6-1:0]      cols_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [5:0] model [CH];

   always #2 clk = ~clk;

   col_loader u_col_loader (
      .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .span_i(span_i), .lanes_i(lanes_i),
      .rport_in(rport_in), .rport_out(rport_out), .rport_oe(rport_oe),
      .lport_in(lport_in), .lport_out(lport_out), .lport_oe(lport_oe),
      .cols_o(cols_o)
   );

   task automatic check_val(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int skip_of(logic [1:0] s);
      case (s)
         2'b01:   return 4;
         2'b10:   return 8;
         2'b11:   return 14;
         default: return 0;
      endcase
   endfunction

   function automatic int len_of(logic [1:0] s);
      case (s)
         2'b01:   return 210;
         2'b10:   return 206;
         2'b11:   return 200;
         default: return 214;
      endcase
   endfunction

   function automatic logic [5:0] code_of(int ch, int seed);
      return 6'((ch * 7 + seed * 13 + 5) % 64);
   endfunction

   task automatic set_start(bit d, bit v);
      if (d) rport_in = v;
      else   lport_in = v;
   endtask

   // Drive one triple over a full period; entry just after a rising edge.
   task automatic feed_pos(int p, int seed, bit d, output bit carry_seen, output bit other_out);
      logic [5:0] cd [GR];
      for (int g = 0; g < GR; g++) cd[g] = code_of(3 * p + g, seed);
      for (int g = 0; g < GR; g++)
         for (int l = 0; l < LN; l++) lanes_i[g*LN + l] = cd[g][2*l];
      @(negedge clk); #1;
      for (int g = 0; g < GR; g++)
         for (int l = 0; l < LN; l++) lanes_i[g*LN + l] = cd[g][2*l + 1];
      carry_seen = d ? lport_out : rport_out;
      other_out  = d ? rport_out : lport_out;
      @(posedge clk); #1;
   endtask

   task automatic pulse_start(bit d, bit wide);
      set_start(d, 1'b1);
      lanes_i = 9'h1A5;
      @(posedge clk); #1;
      if (wide) begin
         lanes_i = 9'h0C3;
         @(posedge clk); #1;
      end
      set_start(d, 1'b0);
   endtask

   task automatic run_line(bit d, logic [1:0] s, int seed, int garbage, bit wide);
      int ord [POS];
      int n = 0;
      int sk = skip_of(s);
      int lo = (POS - sk) / 2;
      int hi = lo + sk - 1;
      int carry_at = -1;
      int ncarry = 0;
      bit c, o;
      dir_i  = d;
      span_i = s;
      for (int i = 0; i < POS; i++) begin
         int p = d ? i : POS - 1 - i;
         if (sk == 0 || p < lo || p > hi) begin
            ord[n] = p;
            n++;
         end
      end
      #1;
      check_val("R5 lport_oe", int'(lport_oe), int'(d));
      check_val("R5 rport_oe", int'(rport_oe), int'(!d));
      pulse_start(d, wide);
      if (garbage > 0) begin
         for (int k = 0; k < garbage; k++) feed_pos(ord[k], seed + 101, d, c, o);
         pulse_start(d, 1'b0);
      end
      for (int k = 0; k < n; k++) begin
         feed_pos(ord[k], seed, d, c, o);
         if (c) begin
            ncarry++;
            carry_at = k;
         end
         if (k == n - 1) check_val("R5 idle port output", int'(o), 0);
         for (int g = 0; g < GR; g++) model[3 * ord[k] + g] = code_of(3 * ord[k] + g, seed);
      end
      check_val("R6 carry pulse count", ncarry, 1);
      check_val("R7 carry period index", carry_at, len_of(s) - 1);
      // R10: lane activity after the line, no start
      for (int k = 0; k < 6; k++) begin
         feed_pos(k * 31 % POS, seed + 7, d, c, o);
         check_val("R10 carry stays low", int'(c), 0);
      end
      lanes_i = '0;
      for (int ch = 0; ch < CH; ch++) begin
         int pos = ch / 3;
         string tag;
         if (sk != 0 && pos >= lo && pos <= hi) tag = $sformatf("R8 removed ch %0d", ch);
         else if (d) tag = $sformatf("R2/R3 ch %0d", ch);
         else        tag = $sformatf("R2/R4 ch %0d", ch);
         check_val(tag, int'(cols_o[ch*6 +: 6]), int'(model[ch]));
      end
   endtask

   initial begin
      #800000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      bit c, o;
      for (int ch = 0; ch < CH; ch++) model[ch] = 6'd0;
      repeat (3) @(posedge clk);
      #1;
      check_val("R1 register cleared in reset", int'(cols_o == '0), 1);
      check_val("R1 carry low in reset", int'(lport_out | rport_out), 0);
      rst_n = 1'b1;
      // R1: lanes active without a start pulse after reset
      for (int k = 0; k < 4; k++) feed_pos(k, 9, 1'b1, c, o);
      check_val("R1 register cleared after reset", int'(cols_o == '0), 1);
      check_val("R1 carry low after reset", int'(lport_out | rport_out), 0);

      for (int i = 0; i < 8; i++)
         run_line(SCEN[i].dir, SCEN[i].span, int'(SCEN[i].seed), 0, 1'b0);

      // R9: restart on a second pulse, both directions
      run_line(1'b1, 2'b00, 120, 30, 1'b0);
      run_line(1'b0, 2'b00, 131, 45, 1'b0);
      // R9: two-period-wide start pulse
      run_line(1'b1, 2'b00, 142, 0, 1'b1);
      run_line(1'b0, 2'b11, 153, 0, 1'b1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule